// File: doc/BRIEF.md
# Paired edge capture for pulse period and high-time measurement

This block measures an external pulse train by latching a shared, free-running timer count into two capture registers. Both capture units listen to the same pin, chosen from a pair of pins. Normally the first unit fires on rising edges and the second on falling edges. The host finds the period from two successive first-unit captures, and the high time from a first-unit capture and the following second-unit capture. That arithmetic, including the correction when the counter wraps between captures, stays outside the block.

Each capture of the first unit raises a one-cycle strobe. A host or DMA engine uses the strobe to fetch both registers together. An edge prescaler shared by both units can thin out captures to one in every 2, 4 or 8 qualifying edges, which makes short periods easier to resolve. Both pins pass through two synchroniser flops. A per-unit overrun flag records a capture that replaced a value nobody had fetched.

Top module: `pwm_capture_pair`

## Requirements
- R1: After reset, both capture registers read 0, and `cap_evt` and both bits of `ovf` are 0.
- R2: A pin change applied between clock edges is latched on the third rising clock edge after it. The capture register takes the `cnt_val` present just before that edge and shows it right after the edge.
- R3: When `pol[i]` is 0, unit i captures on rising edges of its source pin. When `pol[i]` is 1, it captures on falling edges. Unit 0 drives `cap0` and unit 1 drives `cap1`.
- R4: `src_sel` = 0 makes both units use `pin_a`, and `src_sel` = 1 makes both use `pin_b`. Edges on the pin that is not selected change nothing.
- R5: `icpsc` values 0, 1, 2 and 3 make a unit capture on every 1st, 2nd, 4th and 8th qualifying edge. The edge count restarts from zero whenever the unit is disarmed.
- R6: `cap_evt` is high for exactly one cycle, the cycle in which `cap0` takes a new capture. Captures by unit 1 never raise it.
- R7: Unit i is armed only while both `cnt_en` and `cap_en[i]` are 1. A unit that is not armed neither captures nor advances its edge count.
- R8: `ovf[i]` goes to 1 when unit i captures while its previous capture is still unfetched. It stays at 1 until `rd_ack` is seen. `rd_ack` marks both units as fetched.
- R9: If `rd_ack` coincides with a capture, the fetch applies to the old value and no overrun is flagged. The new value is left unfetched, so a later capture without `rd_ack` flags an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Timer counter running |
| cnt_val | input | CNT_W | Shared timer count |
| pin_a | input | 1 | First pin of the pair (asynchronous) |
| pin_b | input | 1 | Second pin of the pair (asynchronous) |
| src_sel | input | 1 | Pin used by both units: 0 pin_a, 1 pin_b |
| pol | input | 2 | Per-unit edge: 0 rising, 1 falling |
| cap_en | input | 2 | Per-unit capture enable |
| icpsc | input | 2 | Edge prescaler code: 1, 2, 4 or 8 edges |
| rd_ack | input | 1 | Host has fetched the capture pair |
| cap0 | output | CNT_W | Unit 0 capture register |
| cap1 | output | CNT_W | Unit 1 capture register |
| cap_evt | output | 1 | One-cycle strobe on each unit 0 capture |
| ovf | output | 2 | Per-unit overrun flag |

## Verification
The bench times each capture against the exact third clock edge after the pin change, so an extra or missing synchroniser stage latches the wrong count. It walks a train in which the counter wraps between pulses, and checks that a falling-edge capture never raises the strobe. It steers edges to the unselected pin, flips the polarity bits, and feeds fewer edges than the prescaler needs. A design that ignored the source select, swapped the edge sense, counted the prescaler one edge off or kept a stale count after disarming would latch where it should not. The bench also lines up a fetch with a capture edge, which catches a design that flags a false overrun or loses track of the fresh value.

// File: rtl/pwm_capture_pair.sv
module pwm_capture_pair #(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             src_sel,
  input  logic [1:0]       pol,
  input  logic [1:0]       cap_en,
  input  logic [1:0]       icpsc,
  input  logic             rd_ack,
  output logic [CNT_W-1:0] cap0,
  output logic [CNT_W-1:0] cap1,
  output logic             cap_evt,
  output logic [1:0]       ovf
);

  localparam int PSC_W = 3;

  logic [SYNC_STAGES-1:0] sync_a, sync_b;
  logic [1:0]             last_q;
  logic [1:0]             cur;
  logic                   src_now, src_last;
  logic                   rise, fall;
  logic [PSC_W-1:0]       limit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      last_q <= '0;
    end else begin
      sync_a <= {sync_a[SYNC_STAGES-2:0], pin_a};
      sync_b <= {sync_b[SYNC_STAGES-2:0], pin_b};
      last_q <= cur;
    end

  assign cur      = {sync_b[SYNC_STAGES-1], sync_a[SYNC_STAGES-1]};
  assign src_now  = cur[src_sel];
  assign src_last = last_q[src_sel];
  assign rise     = src_now & ~src_last;
  assign fall     = ~src_now & src_last;
  assign limit    = PSC_W'((1 << icpsc) - 1);

  logic [CNT_W-1:0] cap_q [2];
  logic [1:0]       take, pend;

  for (genvar u = 0; u < 2; u++) begin : g_unit
    logic             armed, edge_ok;
    logic [PSC_W-1:0] psc_q;

    assign armed   = cnt_en & cap_en[u];
    assign edge_ok = armed & (pol[u] ? fall : rise);
    assign take[u] = edge_ok & (psc_q >= limit);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        psc_q    <= '0;
        cap_q[u] <= '0;
        pend[u]  <= 1'b0;
        ovf[u]   <= 1'b0;
      end else begin
        if (!armed)       psc_q <= '0;
        else if (take[u]) psc_q <= '0;
        else if (edge_ok) psc_q <= psc_q + 1'b1;
        if (take[u]) cap_q[u] <= cnt_val;
        pend[u] <= take[u] | (pend[u] & ~rd_ack);
        ovf[u]  <= (ovf[u] & ~rd_ack) | (take[u] & pend[u] & ~rd_ack);
      end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf[u] && !rd_ack |=> ovf[u]); // R8
    AST_ACK_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack |=> !ovf[u]); // R9
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cap_evt <= 1'b0;
    else        cap_evt <= take[0];

  assign cap0 = cap_q[0];
  assign cap1 = cap_q[1];

  AST_GATE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_en && cap_en[0]) |=> !cap_evt); // R7
  AST_CAP0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |-> $stable(cap0)); // R6
  AST_CAP1_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_en && cap_en[1]) |=> $stable(cap1)); // R7

endmodule

// File: tb/pwm_capture_pair_bench.sv
module pwm_capture_pair_bench;
  logic        clk = 0, rst_n = 0;
  logic        cnt_en = 0, pa = 0, pb = 0, src_sel = 0, rd_ack = 0;
  logic [15:0] cnt_val = 0;
  logic [1:0]  pol = 2'b10, cap_en = 2'b00, icpsc = 0;
  logic [15:0] cap0, cap1;
  logic        cap_evt;
  logic [1:0]  ovf;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_capture_pair #(.CNT_W(16), .SYNC_STAGES(2)) u_pwm_capture_pair (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_val(cnt_val),
    .pin_a(pa), .pin_b(pb), .src_sel(src_sel), .pol(pol), .cap_en(cap_en),
    .icpsc(icpsc), .rd_ack(rd_ack), .cap0(cap0), .cap1(cap1),
    .cap_evt(cap_evt), .ovf(ovf));

  // {level, count, expected cap0, expected cap1, expected strobe}
  localparam logic [49:0] VEC [6] = '{
    {1'b1, 16'd100,   16'd100, 16'd0,     1'b1},
    {1'b0, 16'd160,   16'd100, 16'd160,   1'b0},
    {1'b1, 16'd300,   16'd300, 16'd160,   1'b1},
    {1'b0, 16'd330,   16'd300, 16'd330,   1'b0},
    {1'b1, 16'd10,    16'd10,  16'd330,   1'b1},
    {1'b0, 16'd65530, 16'd10,  16'd65530, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive a pin level and count, then wait until just after the capture edge
  task automatic drive(input bit on_b, input logic lvl, input logic [15:0] cv, input bit ack_at_cap);
    @(negedge clk);
    if (on_b) pb = lvl; else pa = lvl;
    cnt_val = cv;
    @(negedge clk);
    @(negedge clk);
    if (ack_at_cap) rd_ack = 1;
    @(negedge clk);
    rd_ack = 0;
  endtask

  task automatic ack();
    @(negedge clk); rd_ack = 1;
    @(negedge clk); rd_ack = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cap0", cap0, 0);
    chk("R1 cap1", cap1, 0);
    chk("R1 evt", cap_evt, 0);
    chk("R1 ovf", ovf, 0);
    rst_n = 1;
    cnt_en = 1; cap_en = 2'b11;

    for (int i = 0; i < 6; i++) begin
      drive(0, VEC[i][49], VEC[i][48:33], 0);
      chk("R3 cap0", cap0, VEC[i][32:17]);
      chk("R3 cap1", cap1, VEC[i][16:1]);
      chk("R6 evt", cap_evt, VEC[i][0]);
      chk("R8 ovf", ovf, 0);
      ack();
    end

    // R2 latency: not yet after two edges, present after the third
    @(negedge clk); pa = 1; cnt_val = 777;
    @(negedge clk); @(negedge clk);
    chk("R2 early", cap0, 10);
    @(negedge clk);
    chk("R2 latch", cap0, 777);
    chk("R2 evt", cap_evt, 1);
    @(negedge clk);
    chk("R6 one cycle", cap_evt, 0);
    ack();

    // R4 source select
    src_sel = 1;
    drive(0, 0, 900, 0);
    drive(0, 1, 901, 0);
    chk("R4 unselected pin", cap0, 777);
    chk("R4 unselected evt", cap_evt, 0);
    drive(1, 1, 500, 0);
    chk("R4 pin_b capture", cap0, 500);
    ack();

    // R3 swapped polarity
    pol = 2'b01;
    drive(1, 0, 700, 0);
    chk("R3 falling unit0", cap0, 700);
    chk("R3 evt", cap_evt, 1);
    drive(1, 1, 800, 0);
    chk("R3 rising unit1", cap1, 800);
    chk("R6 no evt unit1", cap_evt, 0);
    ack();

    // R5 prescaler divide by 4 on unit 0, rising edges of pin_b
    pol = 2'b00; cap_en = 2'b01; icpsc = 2;
    drive(1, 0, 1000, 0);
    for (int k = 1; k <= 3; k++) begin
      drive(1, 1, 16'(1000 + k), 0);
      drive(1, 0, 1100, 0);
    end
    chk("R5 before 4th edge", cap0, 700);
    drive(1, 1, 1004, 0);
    chk("R5 4th edge", cap0, 1004);
    ack();
    // R5 restart on disarm, divide by 2
    icpsc = 1;
    drive(1, 0, 1200, 0);
    drive(1, 1, 1201, 0);
    drive(1, 0, 1202, 0);
    @(negedge clk); cap_en = 2'b00;
    @(negedge clk); cap_en = 2'b01;
    drive(1, 1, 1203, 0);
    chk("R5 restarted count", cap0, 1004);
    drive(1, 0, 1204, 0);
    drive(1, 1, 1205, 0);
    chk("R5 second after restart", cap0, 1205);
    ack();

    // R7 counter stopped
    icpsc = 0; cnt_en = 0;
    drive(1, 0, 1300, 0);
    drive(1, 1, 1301, 0);
    chk("R7 no capture", cap0, 1205);
    chk("R7 no evt", cap_evt, 0);
    cnt_en = 1;

    // R8 overrun
    ack();
    drive(1, 0, 1400, 0);
    drive(1, 1, 1401, 0);
    chk("R8 first no ovf", ovf[0], 0);
    drive(1, 0, 1402, 0);
    drive(1, 1, 1403, 0);
    chk("R8 overrun", ovf[0], 1);
    repeat (3) @(negedge clk);
    chk("R8 sticky", ovf[0], 1);
    ack();
    chk("R8 cleared", ovf[0], 0);

    // R9 fetch coinciding with capture
    drive(1, 0, 1500, 0);
    drive(1, 1, 1501, 0);
    drive(1, 0, 1502, 0);
    drive(1, 1, 1503, 1);
    chk("R9 no ovf on coincident fetch", ovf[0], 0);
    chk("R9 value", cap0, 1503);
    drive(1, 0, 1504, 0);
    drive(1, 1, 1505, 0);
    chk("R9 new value was pending", ovf[0], 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule